// File: doc/BRIEF.md
# Byte Buffer to Staging Register Channel

This block models the byte accounting of one input channel of a memory interface card. Each clock cycle is one tick. On every tick a fixed batch of bytes arrives: one byte for a narrow (8-bit) channel or two bytes for a wide (16-bit) channel, set by a parameter. The bytes land in a small input buffer. Whenever the buffer holds at least one word of four bytes and the staging register still has room, one word moves from the buffer into the register in that same tick.

When the register holds its full 64 bytes it stops taking words and raises a request for the shared bus. The flush to memory starts when the grant is seen. It occupies the bus for a fixed number of ticks, three by default. Input keeps arriving into the buffer for the whole time. At the end of the flush the register count returns to zero and word transfers resume. The buffer must therefore be deep enough to soak up the input of the waiting and flushing ticks. An incoming batch that would not fit is dropped, and a sticky error flag is raised.

Only byte counts and control are modelled. The memory itself, the arbiter and the data contents lie outside the block.

Top module: `stg_chan`

## Requirements
- R1: While `rst_ni` is low, and on the first cycle after it rises, `buf_cnt_o`, `reg_cnt_o`, `bus_req_o`, `flushing_o` and `overflow_o` are all 0.
- R2: On a tick where the register holds fewer than REG_BYTES and the buffer holds fewer than WORD_BYTES, `buf_cnt_o` grows by IN_BYTES and `reg_cnt_o` is unchanged, provided the result fits in BUF_CAP.
- R3: On a tick where the register holds fewer than REG_BYTES and the buffer holds at least WORD_BYTES, the buffer changes by IN_BYTES minus WORD_BYTES and the register grows by WORD_BYTES.
- R4: While `reg_cnt_o` equals REG_BYTES, no word moves. This holds while waiting for the grant and during the flush. The buffer grows by IN_BYTES on each of these ticks, provided the result fits.
- R5: `bus_req_o` is 1 exactly when `reg_cnt_o` equals REG_BYTES and no flush is in progress.
- R6: A cycle with `bus_req_o` and `bus_gnt_i` both 1 is followed by exactly FLUSH_TICKS cycles with `flushing_o` at 1. During them `reg_cnt_o` stays at REG_BYTES. On the cycle after the last of them, `reg_cnt_o` is 0.
- R7: `bus_gnt_i` while `bus_req_o` is 0 has no effect: no flush starts, and the counts follow R2 and R3.
- R8: On a tick without a word transfer, if adding IN_BYTES would take the buffer above BUF_CAP, the batch is dropped and `buf_cnt_o` is unchanged. `overflow_o` is set and stays 1 until reset.
- R9: Once the buffer has held at least IN_BYTES, it never again holds fewer. With the grant given as soon as it is requested and BUF_CAP large enough for the wait and flush ticks, `overflow_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; one cycle is one tick |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_gnt_i | input | 1 | Shared bus grant |
| buf_cnt_o | output | $clog2(BUF_CAP+1) | Bytes held in the input buffer |
| reg_cnt_o | output | $clog2(REG_BYTES+1) | Bytes held in the staging register |
| bus_req_o | output | 1 | Bus request, register full and not flushing |
| flushing_o | output | 1 | Flush in progress, bus in use |
| overflow_o | output | 1 | Sticky error: an input batch was dropped |

## Verification
The bench goes after the tick on which the register reaches full. A design that still moved a word there would overshoot 64 bytes and never request the bus. It also probes the flush length, where an off-by-one counter would show as a flush one tick short or long and would shift every buffer count after it. A grant with no request is applied to catch a design that starts a spurious flush. Withheld grants drive the buffer to its capacity; a design that saturated wrongly, wrapped, or cleared the error flag would show a count or flag that differs from the model. Both the narrow and the wide batch size are run side by side, so a transfer rule hard-wired to one batch size is caught.

// File: rtl/stg_pkg.sv
package stg_pkg;
  typedef enum logic {
    FL_IDLE  = 1'b0,
    FL_BUSY  = 1'b1
  } flush_state_e;
endpackage

// File: rtl/stg_flush_ctrl.sv
module stg_flush_ctrl #(
  parameter int unsigned FLUSH_TICKS = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic reg_full_i,
  input  logic bus_gnt_i,
  output logic bus_req_o,
  output logic flushing_o,
  output logic flush_done_o
);
  import stg_pkg::*;

  localparam int unsigned CNT_W = (FLUSH_TICKS > 1) ? $clog2(FLUSH_TICKS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FLUSH_TICKS - 1);

  flush_state_e     state_q;
  logic [CNT_W-1:0] cnt_q;

  assign flushing_o   = (state_q == FL_BUSY);
  assign bus_req_o    = reg_full_i && !flushing_o;
  assign flush_done_o = flushing_o && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= FL_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        FL_IDLE: begin
          cnt_q <= '0;
          if (bus_req_o && bus_gnt_i) state_q <= FL_BUSY;
        end
        FL_BUSY: begin
          if (flush_done_o) begin
            state_q <= FL_IDLE;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= FL_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/stg_reg_cnt.sv
module stg_reg_cnt #(
  parameter int unsigned REG_BYTES  = 64,
  parameter int unsigned WORD_BYTES = 4,
  localparam int unsigned REG_W     = $clog2(REG_BYTES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             xfer_i,
  input  logic             clear_i,
  output logic [REG_W-1:0] cnt_o,
  output logic             full_o
);
  logic [REG_W-1:0] cnt_q;

  assign cnt_o  = cnt_q;
  assign full_o = (cnt_q == REG_W'(REG_BYTES));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (xfer_i)  cnt_q <= cnt_q + REG_W'(WORD_BYTES);
  end
endmodule

// File: rtl/stg_buf_cnt.sv
module stg_buf_cnt #(
  parameter int unsigned IN_BYTES   = 1,
  parameter int unsigned BUF_CAP    = 8,
  parameter int unsigned WORD_BYTES = 4,
  localparam int unsigned BUF_W     = $clog2(BUF_CAP + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_full_i,
  output logic             xfer_o,
  output logic [BUF_W-1:0] cnt_o,
  output logic             overflow_o
);
  logic [BUF_W-1:0] cnt_q;
  logic             ovf_q;
  logic [BUF_W:0]   sum;
  logic             no_room;

  assign sum     = {1'b0, cnt_q} + (BUF_W+1)'(IN_BYTES);
  assign xfer_o  = !reg_full_i && (cnt_q >= BUF_W'(WORD_BYTES));
  assign no_room = sum > (BUF_W+1)'(BUF_CAP);
  assign cnt_o      = cnt_q;
  assign overflow_o = ovf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else if (xfer_o) begin
      cnt_q <= BUF_W'(sum - (BUF_W+1)'(WORD_BYTES));
    end else if (no_room) begin
      ovf_q <= 1'b1;  // batch dropped
    end else begin
      cnt_q <= BUF_W'(sum);
    end
  end
endmodule

// File: rtl/stg_chan.sv
module stg_chan #(
  parameter int unsigned IN_BYTES    = 1,
  parameter int unsigned BUF_CAP     = 8,
  parameter int unsigned REG_BYTES   = 64,
  parameter int unsigned WORD_BYTES  = 4,
  parameter int unsigned FLUSH_TICKS = 3,
  localparam int unsigned BUF_W      = $clog2(BUF_CAP + 1),
  localparam int unsigned REG_W      = $clog2(REG_BYTES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bus_gnt_i,
  output logic [BUF_W-1:0] buf_cnt_o,
  output logic [REG_W-1:0] reg_cnt_o,
  output logic             bus_req_o,
  output logic             flushing_o,
  output logic             overflow_o
);
  logic xfer, reg_full, flush_done;

  stg_buf_cnt #(
    .IN_BYTES(IN_BYTES), .BUF_CAP(BUF_CAP), .WORD_BYTES(WORD_BYTES)
  ) u_buf (
    .clk_i, .rst_ni,
    .reg_full_i (reg_full),
    .xfer_o     (xfer),
    .cnt_o      (buf_cnt_o),
    .overflow_o (overflow_o)
  );

  stg_reg_cnt #(
    .REG_BYTES(REG_BYTES), .WORD_BYTES(WORD_BYTES)
  ) u_reg (
    .clk_i, .rst_ni,
    .xfer_i  (xfer),
    .clear_i (flush_done),
    .cnt_o   (reg_cnt_o),
    .full_o  (reg_full)
  );

  stg_flush_ctrl #(
    .FLUSH_TICKS(FLUSH_TICKS)
  ) u_flush (
    .clk_i, .rst_ni,
    .reg_full_i   (reg_full),
    .bus_gnt_i    (bus_gnt_i),
    .bus_req_o    (bus_req_o),
    .flushing_o   (flushing_o),
    .flush_done_o (flush_done)
  );
endmodule

// File: rtl/stg_chan_chk.sv
module stg_chan_chk #(
  parameter int unsigned IN_BYTES    = 1,
  parameter int unsigned BUF_CAP     = 8,
  parameter int unsigned REG_BYTES   = 64,
  parameter int unsigned WORD_BYTES  = 4,
  parameter int unsigned BUF_W       = 4,
  parameter int unsigned REG_W       = 7
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             bus_gnt_i,
  input logic [BUF_W-1:0] buf_cnt_o,
  input logic [REG_W-1:0] reg_cnt_o,
  input logic             bus_req_o,
  input logic             flushing_o,
  input logic             overflow_o
);
  p_rst_r1: assert property (@(posedge clk_i) !rst_ni |=> (buf_cnt_o == '0 && reg_cnt_o == '0 && !overflow_o));

  p_fill_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(reg_cnt_o) < REG_BYTES && int'(buf_cnt_o) < WORD_BYTES && int'(buf_cnt_o) + IN_BYTES <= BUF_CAP)
    |=> (int'(buf_cnt_o) == int'($past(buf_cnt_o)) + IN_BYTES && $stable(reg_cnt_o)));

  p_xfer_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(reg_cnt_o) < REG_BYTES && int'(buf_cnt_o) >= WORD_BYTES)
    |=> (int'(reg_cnt_o) == int'($past(reg_cnt_o)) + WORD_BYTES
         && int'(buf_cnt_o) == int'($past(buf_cnt_o)) + IN_BYTES - WORD_BYTES));

  p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flushing_o |-> int'(reg_cnt_o) == REG_BYTES);

  p_req_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o |-> (int'(reg_cnt_o) == REG_BYTES && !flushing_o));

  p_start_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && bus_gnt_i) |=> flushing_o);

  p_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(flushing_o) |-> reg_cnt_o == '0);

  p_nogo_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bus_req_o && !flushing_o) |=> !flushing_o);

  p_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |=> overflow_o);

  p_floor_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(buf_cnt_o) >= IN_BYTES) |=> (int'(buf_cnt_o) >= IN_BYTES));
endmodule

bind stg_chan stg_chan_chk #(
  .IN_BYTES(IN_BYTES), .BUF_CAP(BUF_CAP), .REG_BYTES(REG_BYTES),
  .WORD_BYTES(WORD_BYTES), .BUF_W(BUF_W), .REG_W(REG_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .bus_gnt_i(bus_gnt_i),
  .buf_cnt_o(buf_cnt_o), .reg_cnt_o(reg_cnt_o), .bus_req_o(bus_req_o),
  .flushing_o(flushing_o), .overflow_o(overflow_o)
);

// File: tb/stg_chan_bench.sv
`timescale 1ns/1ps
module stg_chan_bench;
  localparam int CAP_N = 8;
  localparam int CAP_W = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic gnt = 1'b0;
  always #5 clk = ~clk;

  logic [3:0] buf_n, buf_w;
  logic [6:0] reg_n, reg_w;
  logic req_n, req_w, fl_n, fl_w, ov_n, ov_w;

  stg_chan #(.IN_BYTES(1), .BUF_CAP(CAP_N)) u_stg_chan (
    .clk_i(clk), .rst_ni(rst_n), .bus_gnt_i(gnt),
    .buf_cnt_o(buf_n), .reg_cnt_o(reg_n), .bus_req_o(req_n),
    .flushing_o(fl_n), .overflow_o(ov_n));

  stg_chan #(.IN_BYTES(2), .BUF_CAP(CAP_W)) u_stg_chan_w (
    .clk_i(clk), .rst_ni(rst_n), .bus_gnt_i(gnt),
    .buf_cnt_o(buf_w), .reg_cnt_o(reg_w), .bus_req_o(req_w),
    .flushing_o(fl_w), .overflow_o(ov_w));

  typedef struct { int b; int r; bit f; int c; bit o; bit seen; } mdl_t;
  mdl_t mn, mw;
  string tag_n, tag_w;
  int checks = 0, fails = 0;
  bit done = 0;

  function automatic mdl_t mdl_step(mdl_t m, bit g, int bb, int cap);
    mdl_t n = m;
    bit full = (m.r == 64);
    if (!full && m.b >= 4) begin n.b = m.b + bb - 4; n.r = m.r + 4; end
    else if (m.b + bb > cap) n.o = 1;
    else n.b = m.b + bb;
    if (m.f) begin
      if (m.c == 2) begin n.f = 0; n.c = 0; n.r = 0; end
      else n.c = m.c + 1;
    end else if (full && g) begin n.f = 1; n.c = 0; end
    if (n.b >= bb) n.seen = 1;
    return n;
  endfunction

  function automatic string buf_tag(mdl_t m, int bb, int cap);
    if (m.r == 64) return (m.b + bb > cap) ? "R8" : "R4";
    if (m.b >= 4) return "R3";
    return (m.b + bb > cap) ? "R8" : "R2";
  endfunction

  task automatic chk(bit ok, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic cmp(string nm, string tg, mdl_t m, int bb,
                     int b, int r, bit q, bit f, bit o);
    chk(b == m.b, {tg, " buf ", nm}, b, m.b);
    chk(r == m.r, {"R3 reg ", nm}, r, m.r);
    chk(q == (m.r == 64 && !m.f), {"R5 req ", nm}, q, m.r == 64 && !m.f);
    chk(f == m.f, {"R6 flushing ", nm}, f, m.f);
    chk(o == m.o, {"R8 overflow ", nm}, o, m.o);
    if (m.seen) chk(b >= bb, {"R9 floor ", nm}, b, bb);
  endtask

  task automatic tick(bit g);
    gnt = g;
    tag_n = buf_tag(mn, 1, CAP_N);
    tag_w = buf_tag(mw, 2, CAP_W);
    @(posedge clk);
    mn = mdl_step(mn, g, 1, CAP_N);
    mw = mdl_step(mw, g, 2, CAP_W);
    @(negedge clk);
    cmp("narrow", tag_n, mn, 1, int'(buf_n), int'(reg_n), req_n, fl_n, ov_n);
    cmp("wide", tag_w, mw, 2, int'(buf_w), int'(reg_w), req_w, fl_w, ov_w);
  endtask

  task automatic do_reset();
    gnt = 0;
    @(negedge clk);
    rst_n = 0;
    mn = '{default: 0};
    mw = '{default: 0};
    @(negedge clk);
    chk(buf_n == 0 && reg_n == 0 && !req_n && !fl_n && !ov_n, "R1 reset narrow", int'(buf_n), 0);
    chk(buf_w == 0 && reg_w == 0 && !req_w && !fl_w && !ov_w, "R1 reset wide", int'(buf_w), 0);
    rst_n = 1;
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    do_reset();
    // R7: grant with no request
    for (int i = 0; i < 12; i++) begin
      tick(1'b1);
      chk(!fl_n && !fl_w, "R7 no flush without request", int'(fl_n), 0);
    end
    // immediate grant: R9 no overflow expected
    for (int i = 0; i < 600; i++) tick(req_n | req_w);
    chk(!ov_n && !ov_w, "R9 no overflow with prompt grant", int'(ov_n | ov_w), 0);
    // grant withheld: fills to full, then buffer to capacity, R8
    do_reset();
    for (int i = 0; i < 120; i++) tick(1'b0);
    chk(ov_n && int'(buf_n) == CAP_N, "R8 narrow at cap", int'(buf_n), CAP_N);
    chk(ov_w && int'(buf_w) == CAP_W, "R8 wide at cap", int'(buf_w), CAP_W);
    for (int i = 0; i < 200; i++) tick(($urandom % 3) == 0);
    chk(ov_n && ov_w, "R8 overflow held", int'(ov_n & ov_w), 1);
    // constrained random grants
    for (int k = 0; k < 6; k++) begin
      do_reset();
      for (int i = 0; i < 1500; i++) tick(($urandom % (k + 2)) == 0);
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule